// File: doc/BRIEF.md
# Integer Register File with Zero / Stack-Pointer Alias

This block is the integer register file of a load/store processor datapath. It stores thirty-one 64-bit general-purpose registers and a separate 64-bit stack pointer. It has two combinational read ports and one write port that updates on the rising clock edge. Instruction decode, the program counter, mode banking and the vector register file all sit outside the block. None of them can be reached through its ports.

Every port carries a 5-bit register index, an alias select and a width select. Index 31 never names an array entry. On each access, the alias select picks what it means. With the select low it is a hard zero: reads give 0 and writes are dropped. With the select high it is the stack pointer. The width select gives either the full 64-bit register or a 32-bit view of its low half. No register is banked, so each one exists exactly once.

Top module: `intreg_file`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears all 31 general-purpose registers and the stack pointer to zero.
- R2: A 64-bit write (`wr_en`=1, `wr_narrow`=0) to an index from 0 to 30 stores `wr_data` in that register at the rising edge. Reading that index afterwards returns the stored value.
- R3: A 32-bit write (`wr_narrow`=1) stores `wr_data[31:0]` in bits 31:0 of the destination and clears its bits 63:32.
- R4: A 32-bit read (`rdN_narrow`=1) returns bits 31:0 of the selected register, with bits 63:32 of the read bus at zero.
- R5: A read of index 31 with the alias select low (`rdN_sp_sel`=0) returns all zeros in both widths.
- R6: A write to index 31 with `wr_sp_sel`=0 is discarded. Neither the stack pointer nor any general-purpose register changes.
- R7: Index 31 with the alias select high (`*_sp_sel`=1) reads and writes the stack pointer. The stack pointer is separate from register 30 and from every other general-purpose register.
- R8: A read is combinational. A read of a register that is being written in the same cycle returns the old value, with no write-through bypass.
- R9: With `wr_en`=0, no register and not the stack pointer changes, whatever the other write inputs are.
- R10: The two read ports work independently and may select any index, alias and width in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and reset act on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd0_idx | input | 5 | Read port 0 register index |
| rd0_sp_sel | input | 1 | Read port 0: index 31 means the stack pointer (1) or zero (0) |
| rd0_narrow | input | 1 | Read port 0: 32-bit view (1) or 64-bit (0) |
| rd0_data | output | 64 | Read port 0 data |
| rd1_idx | input | 5 | Read port 1 register index |
| rd1_sp_sel | input | 1 | Read port 1: index 31 alias select |
| rd1_narrow | input | 1 | Read port 1: width select |
| rd1_data | output | 64 | Read port 1 data |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Write register index |
| wr_sp_sel | input | 1 | Write: index 31 means the stack pointer (1) or zero (0) |
| wr_narrow | input | 1 | Write: 32-bit write that clears the upper half (1) or 64-bit (0) |
| wr_data | input | 64 | Write data |

## Verification
Random traffic uses indices that lean toward 30 and 31 and data whose upper and lower halves differ. This separates a 32-bit view from a full read and makes any packing or half mix-up visible. Index 31 is exercised with both alias selects on reads and writes. This separates a discarded zero-write from a stack-pointer update, and the stack pointer from register 30. Reads that hit the register being written in the same cycle separate the required old-value behaviour from a bypass. Directed steps cover a narrow write over an all-ones register, a write with the enable low, and a reset issued after traffic.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int DATA_W = 64;
  localparam int REG_CNT = 31;
  localparam int IDX_W = $clog2(REG_CNT + 1);

  // Widens a value to the full register, keeping only the low half when narrow.
  function automatic logic [DATA_W-1:0] half_view(input logic [DATA_W-1:0] v, input logic narrow);
    half_view = narrow ? {{(DATA_W/2){1'b0}}, v[DATA_W/2-1:0]} : v;
  endfunction
endpackage

// File: rtl/rf_gpr_store.sv
module rf_gpr_store #(
  parameter int NREG = rf_pkg::REG_CNT,
  parameter int XLEN = rf_pkg::DATA_W,
  parameter int IDXW = rf_pkg::IDX_W,
  parameter int NRD  = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      we,
  input  logic [IDXW-1:0]           widx,
  input  logic [XLEN-1:0]           wval,
  input  logic [NRD-1:0][IDXW-1:0]  rd_idx,
  output logic [NRD-1:0][XLEN-1:0]  rd_raw
);
  logic [XLEN-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (we) begin
      mem[widx] <= wval;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd_raw[g] = (32'(rd_idx[g]) < NREG) ? mem[rd_idx[g]] : '0;
  end

  // R2: a committed write is held in the addressed entry afterwards
  a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
    we |=> mem[$past(widx)] == $past(wval));
  a_r7_gpr_index_in_range: assert property (@(posedge clk) disable iff (rst)
    we |-> 32'(widx) < NREG);
endmodule

// File: rtl/rf_sp_reg.sv
module rf_sp_reg #(
  parameter int XLEN = rf_pkg::DATA_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [XLEN-1:0] wval,
  output logic [XLEN-1:0] sp_q
);
  always_ff @(posedge clk) begin
    if (rst) sp_q <= '0;
    else if (we) sp_q <= wval;
  end

  // R1: first cycle after reset sees a cleared stack pointer
  a_r1_sp_cleared: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> sp_q == '0);
  // R9/R6: without a stack-pointer write the value holds
  a_r6_sp_holds: assert property (@(posedge clk) disable iff (rst)
    !we |=> sp_q == $past(sp_q));
endmodule

// File: rtl/rf_alias_view.sv
module rf_alias_view #(
  parameter int XLEN = rf_pkg::DATA_W,
  parameter int IDXW = rf_pkg::IDX_W
) (
  input  logic [IDXW-1:0] idx,
  input  logic            sp_sel,
  input  logic            narrow,
  input  logic [XLEN-1:0] gpr_raw,
  input  logic [XLEN-1:0] sp_q,
  output logic [XLEN-1:0] data
);
  localparam logic [IDXW-1:0] ALIAS_IDX = '1;

  logic            is_alias;
  logic [XLEN-1:0] picked;

  always_comb begin
    is_alias = (idx == ALIAS_IDX);
    if (!is_alias)   picked = gpr_raw;
    else if (sp_sel) picked = sp_q;
    else             picked = '0;
    data = rf_pkg::half_view(picked, narrow);
  end
endmodule

// File: rtl/intreg_file.sv
module intreg_file #(
  parameter int XLEN = rf_pkg::DATA_W,
  parameter int NREG = rf_pkg::REG_CNT,
  parameter int IDXW = rf_pkg::IDX_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [IDXW-1:0] rd0_idx,
  input  logic            rd0_sp_sel,
  input  logic            rd0_narrow,
  output logic [XLEN-1:0] rd0_data,
  input  logic [IDXW-1:0] rd1_idx,
  input  logic            rd1_sp_sel,
  input  logic            rd1_narrow,
  output logic [XLEN-1:0] rd1_data,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic            wr_sp_sel,
  input  logic            wr_narrow,
  input  logic [XLEN-1:0] wr_data
);
  localparam int NRD = 2;
  localparam logic [IDXW-1:0] ALIAS_IDX = '1;

  logic                     wr_to_alias;
  logic                     wr_gpr_hit;
  logic                     wr_sp_hit;
  logic [XLEN-1:0]          wr_value;
  logic [XLEN-1:0]          sp_q;
  logic [NRD-1:0][IDXW-1:0] rd_idx;
  logic [NRD-1:0]           rd_sp_sel;
  logic [NRD-1:0]           rd_narrow;
  logic [NRD-1:0][XLEN-1:0] rd_raw;
  logic [NRD-1:0][XLEN-1:0] rd_out;

  assign wr_to_alias = (wr_idx == ALIAS_IDX);
  assign wr_gpr_hit  = wr_en && !wr_to_alias;
  assign wr_sp_hit   = wr_en && wr_to_alias && wr_sp_sel;
  assign wr_value    = rf_pkg::half_view(wr_data, wr_narrow);

  assign rd_idx    = {rd1_idx, rd0_idx};
  assign rd_sp_sel = {rd1_sp_sel, rd0_sp_sel};
  assign rd_narrow = {rd1_narrow, rd0_narrow};
  assign rd0_data  = rd_out[0];
  assign rd1_data  = rd_out[1];

  rf_gpr_store #(.NREG(NREG), .XLEN(XLEN), .IDXW(IDXW), .NRD(NRD)) u_store (
    .clk(clk), .rst(rst), .we(wr_gpr_hit), .widx(wr_idx), .wval(wr_value),
    .rd_idx(rd_idx), .rd_raw(rd_raw));

  rf_sp_reg #(.XLEN(XLEN)) u_sp (
    .clk(clk), .rst(rst), .we(wr_sp_hit), .wval(wr_value), .sp_q(sp_q));

  for (genvar g = 0; g < NRD; g++) begin : g_port
    rf_alias_view #(.XLEN(XLEN), .IDXW(IDXW)) u_view (
      .idx(rd_idx[g]), .sp_sel(rd_sp_sel[g]), .narrow(rd_narrow[g]),
      .gpr_raw(rd_raw[g]), .sp_q(sp_q), .data(rd_out[g]));
  end

  // R5: zero alias reads as zero on port 0
  a_r5_zero_alias_read: assert property (@(posedge clk) disable iff (rst)
    (rd0_idx == ALIAS_IDX && !rd0_sp_sel) |-> rd0_data == '0);
  // R4: narrow read keeps the upper half of the bus clear on port 1
  a_r4_narrow_read_upper: assert property (@(posedge clk) disable iff (rst)
    rd1_narrow |-> rd1_data[XLEN-1:XLEN/2] == '0);
  // R6: a zero-alias write never reaches either store
  a_r6_zero_write_dropped: assert property (@(posedge clk) disable iff (rst)
    (wr_to_alias && !wr_sp_sel) |-> !(wr_gpr_hit || wr_sp_hit));
  // R7: stack pointer reads back what was written to it
  a_r7_sp_write_read: assert property (@(posedge clk) disable iff (rst)
    wr_sp_hit |=> sp_q == $past(wr_value));
endmodule

// File: tb/intreg_file_bench.sv
module intreg_file_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 100000;

  logic        clk = 0;
  logic        rst = 1;
  logic [4:0]  rd0_idx = 0, rd1_idx = 0, wr_idx = 0;
  logic        rd0_sp_sel = 0, rd0_narrow = 0, rd1_sp_sel = 0, rd1_narrow = 0;
  logic        wr_en = 0, wr_sp_sel = 0, wr_narrow = 0;
  logic [63:0] wr_data = 0;
  logic [63:0] rd0_data, rd1_data;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  logic [63:0] m [31];
  logic [63:0] sp_m;

  always #(CLK_PERIOD/2) clk = ~clk;

  intreg_file u_intreg_file (
    .clk(clk), .rst(rst),
    .rd0_idx(rd0_idx), .rd0_sp_sel(rd0_sp_sel), .rd0_narrow(rd0_narrow), .rd0_data(rd0_data),
    .rd1_idx(rd1_idx), .rd1_sp_sel(rd1_sp_sel), .rd1_narrow(rd1_narrow), .rd1_data(rd1_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_sp_sel(wr_sp_sel), .wr_narrow(wr_narrow), .wr_data(wr_data));

  function automatic logic [63:0] expect_rd(input logic [4:0] idx, input logic sp, input logic nar);
    logic [63:0] v;
    if (idx == 5'd31) v = sp ? sp_m : 64'd0;
    else v = m[idx];
    return nar ? {32'd0, v[31:0]} : v;
  endfunction

  function automatic string auto_tag(input logic [4:0] idx, input logic sp, input logic nar);
    if (wr_en && idx == wr_idx && !(idx == 5'd31 && !sp)) return "R8";
    if (idx == 5'd31) return sp ? "R7" : "R5";
    if (nar) return "R4";
    return "R2";
  endfunction

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic model_update();
    logic [63:0] v;
    if (rst) begin
      for (int i = 0; i < 31; i++) m[i] = 0;
      sp_m = 0;
    end else if (wr_en && !(wr_idx == 5'd31 && !wr_sp_sel)) begin
      v = wr_narrow ? {32'd0, wr_data[31:0]} : wr_data;
      if (wr_idx == 5'd31) sp_m = v;
      else m[wr_idx] = v;
    end
  endtask

  // Drive one cycle at the falling edge, check both reads, then commit.
  task automatic step(input string tag,
                      input logic [4:0] a0, input logic s0, input logic n0,
                      input logic [4:0] a1, input logic s1, input logic n1,
                      input logic we, input logic [4:0] wa, input logic ws,
                      input logic wn, input logic [63:0] wd);
    @(negedge clk);
    rd0_idx = a0; rd0_sp_sel = s0; rd0_narrow = n0;
    rd1_idx = a1; rd1_sp_sel = s1; rd1_narrow = n1;
    wr_en = we; wr_idx = wa; wr_sp_sel = ws; wr_narrow = wn; wr_data = wd;
    #1;
    check(tag != "" ? tag : auto_tag(a0, s0, n0), rd0_data, expect_rd(a0, s0, n0));
    check(tag != "" ? tag : {"R10/", auto_tag(a1, s1, n1)}, rd1_data, expect_rd(a1, s1, n1));
    @(posedge clk);
    model_update();
  endtask

  task automatic rd_only(input string tag, input logic [4:0] a, input logic s, input logic n);
    step(tag, a, s, n, a, s, n, 1'b0, 5'd0, 1'b0, 1'b0, 64'd0);
  endtask

  function automatic logic [4:0] pick_idx();
    int r = $urandom_range(0, 9);
    if (r < 2) return 5'd31;
    if (r < 3) return 5'd30;
    return 5'($urandom_range(0, 31));
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got %0d cycles expected under %0d", cycles, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 31; i++) m[i] = 0;
    sp_m = 0;
    rst = 1;
    repeat (2) @(posedge clk);
    model_update();
    @(negedge clk);
    rst = 0;

    // R1 after the initial reset
    for (int i = 0; i < 32; i++) rd_only("R1", 5'(i), 1'b1, 1'b0);

    // R3: narrow write over an all-ones register
    step("R2", 5'd5, 0, 0, 5'd5, 0, 0, 1, 5'd5, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF);
    step("R8", 5'd5, 0, 0, 5'd5, 0, 1, 1, 5'd5, 0, 1, 64'hDEAD_BEEF_1234_5678);
    rd_only("R3", 5'd5, 1'b0, 1'b0);

    // R7: stack pointer separate from register 30
    step("R7", 5'd30, 0, 0, 5'd31, 1, 0, 1, 5'd30, 1, 0, 64'h3030_3030_0000_0030);
    step("R7", 5'd30, 0, 0, 5'd31, 1, 0, 1, 5'd31, 1, 0, 64'h5151_0000_7777_0001);
    rd_only("R7", 5'd31, 1'b1, 1'b0);
    rd_only("R7", 5'd30, 1'b0, 1'b0);

    // R6: zero-alias write discarded
    step("R6", 5'd31, 1, 0, 5'd30, 0, 0, 1, 5'd31, 0, 0, 64'hAAAA_BBBB_CCCC_DDDD);
    rd_only("R6", 5'd31, 1'b1, 1'b0);
    rd_only("R6", 5'd30, 1'b0, 1'b0);
    rd_only("R5", 5'd31, 1'b0, 1'b1);

    // R9: write inputs active but enable low
    step("R9", 5'd7, 0, 0, 5'd31, 1, 0, 0, 5'd7, 0, 0, 64'h0123_4567_89AB_CDEF);
    rd_only("R9", 5'd7, 1'b0, 1'b0);
    step("R9", 5'd7, 0, 0, 5'd31, 1, 0, 0, 5'd31, 1, 0, 64'h0123_4567_89AB_CDEF);
    rd_only("R9", 5'd31, 1'b1, 1'b0);

    // Constrained random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [4:0] wa;
      wa = pick_idx();
      step("", pick_idx(), 1'($urandom), 1'($urandom),
           ($urandom_range(0, 3) == 0) ? wa : pick_idx(), 1'($urandom), 1'($urandom),
           1'($urandom_range(0, 3) != 0), wa, 1'($urandom), 1'($urandom),
           {$urandom, $urandom});
    end

    // R1: reset after traffic clears everything
    @(negedge clk);
    rst = 1;
    wr_en = 0;
    @(posedge clk);
    model_update();
    @(negedge clk);
    rst = 0;
    for (int i = 0; i < 32; i++) rd_only("R1", 5'(i), 1'b1, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule